// File: doc/BRIEF.md
# NAND Ready-Wait Status Poller

This block runs after an array operation (page read, program, erase or device reset) has been sent to a serial NAND device. It waits until the device reports ready. It first holds off for an initial delay. It then asks a transaction serializer to perform a one-byte status-register read, and it repeats that read at a fixed poll spacing for as long as the device reports busy. Both delays depend on the kind of operation that was started. All time is counted in pulses of a one-cycle microsecond tick input, so the block does not depend on the system clock rate.

When the device reports ready, the block emits a one-cycle result. The result carries the raw status byte and the flags decoded from it: the busy bit, erase failure, program failure and a two-bit ECC outcome. If the device still reports busy after the timeout budget has elapsed since start, the block gives up and flags a timeout. The serializer frames the actual transaction and returns the byte that was read. That framing lies outside this block.

Top module: `nand_ready_poller`

## Requirements
- R1: After reset, `desc_valid` and `done` are low, and microsecond ticks that arrive while no operation is running start nothing.
- R2: After `start`, the first descriptor is raised after exactly the initial delay counted in ticks. The operation codes on `start_op` are 0 = page read (6 us), 1 = program (75 us), 2 = erase (250 us) and 3 = reset (5 us).
- R3: Each descriptor requests opcode 0x0F at register address 0xC0. `desc_valid` stays high until the cycle in which `desc_ready` is seen.
- R4: A returned status byte with bit 0 set (busy) raises the next descriptor after exactly the poll interval for the running operation: read 5 us, program 15 us, erase 50 us, reset 5 us. No result is produced for such a byte.
- R5: A returned status byte with bit 0 clear produces `done` on the cycle after `rsp_valid`. The result carries the byte on `res_status`, `res_busy` = 0, `res_erase_fail` = bit 2, `res_prog_fail` = bit 3 and `res_timeout` = 0.
- R6: `res_ecc` is taken from status bits 5:4. Code 0 means clean, 1 means corrected and 2 means uncorrectable. The reserved code 3 is reported as 2.
- R7: A busy status byte that arrives when at least TIMEOUT_US ticks (default 400000, i.e. 400 ms) have elapsed since start ends the operation. The block then raises `done` with `res_timeout` = 1 and `res_busy` = 1, and issues no further descriptor.
- R8: A `start` pulse while an operation is running is ignored. Neither the operation kind nor the delays in force change.
- R9: `done` is a one-cycle pulse. `desc_valid` is low from the descriptor's acceptance until the response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin waiting for the device (sampled when idle) |
| start_op | input | 2 | Operation kind: 0 read, 1 program, 2 erase, 3 reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| desc_valid | output | 1 | Status-read descriptor offered to the serializer |
| desc_ready | input | 1 | Serializer accepts the descriptor |
| desc_opcode | output | 8 | Opcode of the requested transaction |
| desc_addr | output | 8 | Register address of the requested transaction |
| rsp_valid | input | 1 | Serializer returns the status byte |
| rsp_data | input | 8 | Status byte read from the device |
| done | output | 1 | One-cycle result strobe |
| res_status | output | 8 | Last status byte |
| res_busy | output | 1 | Busy bit of the last status byte |
| res_erase_fail | output | 1 | Erase failure flag |
| res_prog_fail | output | 1 | Program failure flag |
| res_timeout | output | 1 | Gave up while the device was still busy |
| res_ecc | output | 2 | ECC outcome: 0 clean, 1 corrected, 2 uncorrectable |

## Verification
The bench targets the exact tick count before each descriptor for every operation kind. A counter that is off by one, or that picks the delay of the wrong operation, lands one tick early or late, or takes the erase spacing for a read. It sweeps all four ECC codes against several fail-bit patterns. A decoder that passes code 3 through, or swaps the two fail bits, shows up at once. It drives busy responses up to and beyond the timeout budget, so a design that compares with the wrong bound polls one time too many or too few, or fails to flag busy on a timeout. It also pulses `start` in mid-wait and sends ticks while idle. A design that reloads on the second start, or lets idle ticks shorten the first delay, misplaces the first or second descriptor.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } nrp_op_e;

  typedef struct packed {
    logic       busy;
    logic       erase_fail;
    logic       prog_fail;
    logic [1:0] ecc;
  } nrp_flags_t;

  localparam logic [7:0] GET_FEATURE_OPCODE = 8'h0F;
  localparam logic [7:0] STATUS_REG_ADDR    = 8'hC0;

  localparam int unsigned BUSY_BIT   = 0;
  localparam int unsigned EFAIL_BIT  = 2;
  localparam int unsigned PFAIL_BIT  = 3;
  localparam int unsigned ECC_LO_BIT = 4;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/nrp_tick_timer.sv
module nrp_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && tick && cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expire = run && tick && (cnt_q == W'(1));

  // a single expiry per loaded interval (R2, R4)
  p_single_expire_r2: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

endmodule

// File: rtl/nrp_elapsed.sv
module nrp_elapsed #(
  parameter int unsigned LIMIT = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic over
);

  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (run && tick && cnt_q != LIM) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign over = (cnt_q == LIM);

  // the elapsed count saturates and never wraps (R7)
  p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
    (over && !clr) |=> over);

endmodule

// File: rtl/nrp_status_decode.sv
module nrp_status_decode
  import nrp_pkg::*;
(
  input  logic [7:0] status,
  output nrp_flags_t flags
);

  logic [1:0] raw_ecc;

  always_comb begin
    raw_ecc          = status[ECC_LO_BIT +: 2];
    flags.busy       = status[BUSY_BIT];
    flags.erase_fail = status[EFAIL_BIT];
    flags.prog_fail  = status[PFAIL_BIT];
    flags.ecc        = (raw_ecc == 2'd3) ? 2'd2 : raw_ecc;
  end

endmodule

// File: rtl/nand_ready_poller.sv
module nand_ready_poller
  import nrp_pkg::*;
#(
  parameter int unsigned INIT_READ_US  = 6,
  parameter int unsigned POLL_READ_US  = 5,
  parameter int unsigned INIT_PROG_US  = 75,
  parameter int unsigned POLL_PROG_US  = 15,
  parameter int unsigned INIT_ERASE_US = 250,
  parameter int unsigned POLL_ERASE_US = 50,
  parameter int unsigned INIT_RESET_US = 5,
  parameter int unsigned POLL_RESET_US = 5,
  parameter int unsigned TIMEOUT_US    = 400000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] start_op,
  input  logic       us_tick,
  output logic       desc_valid,
  input  logic       desc_ready,
  output logic [7:0] desc_opcode,
  output logic [7:0] desc_addr,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  output logic       done,
  output logic [7:0] res_status,
  output logic       res_busy,
  output logic       res_erase_fail,
  output logic       res_prog_fail,
  output logic       res_timeout,
  output logic [1:0] res_ecc
);

  localparam int unsigned MAX_INIT = max4(INIT_READ_US, INIT_PROG_US, INIT_ERASE_US, INIT_RESET_US);
  localparam int unsigned MAX_POLL = max4(POLL_READ_US, POLL_PROG_US, POLL_ERASE_US, POLL_RESET_US);
  localparam int unsigned MAX_DLY  = (MAX_INIT > MAX_POLL) ? MAX_INIT : MAX_POLL;
  localparam int unsigned DLY_W    = $clog2(MAX_DLY + 1);
  localparam int unsigned N_OPS    = 4;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ISSUE, S_RESP} state_e;

  function automatic int unsigned init_of(input int unsigned k);
    case (k)
      0:       return INIT_READ_US;
      1:       return INIT_PROG_US;
      2:       return INIT_ERASE_US;
      default: return INIT_RESET_US;
    endcase
  endfunction

  function automatic int unsigned poll_of(input int unsigned k);
    case (k)
      0:       return POLL_READ_US;
      1:       return POLL_PROG_US;
      2:       return POLL_ERASE_US;
      default: return POLL_RESET_US;
    endcase
  endfunction

  logic [DLY_W-1:0] init_tab [N_OPS];
  logic [DLY_W-1:0] poll_tab [N_OPS];

  for (genvar g = 0; g < N_OPS; g++) begin : g_delay_tab
    assign init_tab[g] = DLY_W'(init_of(g));
    assign poll_tab[g] = DLY_W'(poll_of(g));
  end

  state_e     state_q;
  logic [1:0] op_q;
  logic       over;
  logic       expire;
  logic       tmr_load;
  logic [DLY_W-1:0] tmr_val;
  nrp_flags_t flags;
  logic       rsp_take;
  logic       rsp_busy;

  assign rsp_take = (state_q == S_RESP) && rsp_valid;
  assign rsp_busy = rsp_data[BUSY_BIT];

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = poll_tab[op_q];
    if (state_q == S_IDLE) begin
      tmr_load = start;
      tmr_val  = init_tab[start_op];
    end else if (rsp_take && rsp_busy && !over) begin
      tmr_load = 1'b1;
    end
  end

  nrp_tick_timer #(.W(DLY_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (state_q == S_WAIT),
    .tick     (us_tick),
    .expire   (expire)
  );

  nrp_elapsed #(.LIMIT(TIMEOUT_US)) u_elapsed (
    .clk  (clk),
    .rst  (rst),
    .clr  (state_q == S_IDLE),
    .run  (state_q != S_IDLE),
    .tick (us_tick),
    .over (over)
  );

  nrp_status_decode u_decode (
    .status (rsp_data),
    .flags  (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= S_IDLE;
      op_q           <= 2'd0;
      done           <= 1'b0;
      res_status     <= '0;
      res_busy       <= 1'b0;
      res_erase_fail <= 1'b0;
      res_prog_fail  <= 1'b0;
      res_timeout    <= 1'b0;
      res_ecc        <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            op_q    <= start_op;
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (expire) state_q <= S_ISSUE;
        end
        S_ISSUE: begin
          if (desc_ready) state_q <= S_RESP;
        end
        S_RESP: begin
          if (rsp_valid) begin
            if (rsp_busy && !over) begin
              state_q <= S_WAIT;
            end else begin
              state_q        <= S_IDLE;
              done           <= 1'b1;
              res_status     <= rsp_data;
              res_busy       <= flags.busy;
              res_erase_fail <= flags.erase_fail;
              res_prog_fail  <= flags.prog_fail;
              res_ecc        <= flags.ecc;
              res_timeout    <= rsp_busy;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign desc_valid  = (state_q == S_ISSUE);
  assign desc_opcode = GET_FEATURE_OPCODE;
  assign desc_addr   = STATUS_REG_ADDR;

  p_desc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_ready) |=> desc_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_desc_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !desc_valid);

  p_ecc_legal_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_ecc != 2'd3));

  p_timeout_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (done && res_timeout) |-> res_busy);

  p_ready_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !res_timeout) |-> !res_busy);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (start && state_q != S_IDLE) |=> $stable(op_q));

endmodule

// File: tb/nand_ready_poller_test.sv
module nand_ready_poller_test;

  localparam int IR = 3, PR = 2, IP = 4, PP = 3, IE = 6, PE = 4, IS = 2, PS = 1;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] start_op = 2'd0;
  logic us_tick = 1'b0;
  logic desc_ready = 1'b0;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic desc_valid, done, res_busy, res_erase_fail, res_prog_fail, res_timeout;
  logic [7:0] desc_opcode, desc_addr, res_status;
  logic [1:0] res_ecc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  nand_ready_poller #(
    .INIT_READ_US(IR), .POLL_READ_US(PR), .INIT_PROG_US(IP), .POLL_PROG_US(PP),
    .INIT_ERASE_US(IE), .POLL_ERASE_US(PE), .INIT_RESET_US(IS), .POLL_RESET_US(PS),
    .TIMEOUT_US(TMO)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op), .us_tick(us_tick),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_opcode(desc_opcode),
    .desc_addr(desc_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done),
    .res_status(res_status), .res_busy(res_busy), .res_erase_fail(res_erase_fail),
    .res_prog_fail(res_prog_fail), .res_timeout(res_timeout), .res_ecc(res_ecc)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int exp_init(input int op);
    case (op) 0: return IR; 1: return IP; 2: return IE; default: return IS; endcase
  endfunction

  function automatic int exp_poll(input int op);
    case (op) 0: return PR; 1: return PP; 2: return PE; default: return PS; endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_desc(input int gap, output int ticks, output bit ok);
    ticks = 0;
    ok = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (desc_valid) begin
        ok = 1'b1;
        break;
      end
      us_tick = ((c % gap) == gap - 1);
      if (us_tick) ticks++;
      step();
    end
    us_tick = 1'b0;
  endtask

  task automatic do_start(input int op);
    start = 1'b1;
    start_op = 2'(op);
    step();
    start = 1'b0;
  endtask

  task automatic accept_desc(input int hold);
    chk("R3", "opcode", desc_opcode, 8'h0F);
    chk("R3", "address", desc_addr, 8'hC0);
    for (int h = 0; h < hold; h++) begin
      step();
      chk("R3", "valid held", desc_valid, 1);
    end
    desc_ready = 1'b1;
    step();
    desc_ready = 1'b0;
    chk("R9", "valid low after accept", desc_valid, 0);
    step();
    chk("R9", "no done before response", done, 0);
  endtask

  task automatic respond(input logic [7:0] b);
    rsp_valid = 1'b1;
    rsp_data = b;
    step();
    rsp_valid = 1'b0;
  endtask

  task automatic check_result(input logic [7:0] s, input bit tmo);
    int raw;
    raw = int'(s[5:4]);
    chk(tmo ? "R7" : "R5", "done", done, 1);
    chk("R5", "status byte", res_status, s);
    chk(tmo ? "R7" : "R5", "busy flag", res_busy, int'(tmo));
    chk("R7", "timeout flag", res_timeout, int'(tmo));
    chk("R5", "erase fail", res_erase_fail, int'(s[2]));
    chk("R5", "program fail", res_prog_fail, int'(s[3]));
    chk("R6", "ecc", res_ecc, (raw == 3) ? 2 : raw);
    step();
    chk("R9", "done one cycle", done, 0);
  endtask

  task automatic run_txn(input int op, input int nbusy, input logic [7:0] fin,
                         input int gap, input int hold);
    int t;
    bit ok;
    do_start(op);
    for (int i = 0; i <= nbusy; i++) begin
      wait_desc(gap, t, ok);
      chk("R2", "descriptor seen", int'(ok), 1);
      if (i == 0) chk("R2", "initial ticks", t, exp_init(op));
      else        chk("R4", "poll ticks", t, exp_poll(op));
      accept_desc(hold);
      if (i < nbusy) begin
        respond({fin[7:1], 1'b1});
        chk("R4", "no done on busy", done, 0);
      end else begin
        respond(fin);
        check_result(fin, 1'b0);
      end
    end
  endtask

  task automatic run_timeout(input int op, input int gap);
    int t;
    int total;
    bit ok;
    logic [7:0] b;
    total = 0;
    do_start(op);
    for (int i = 0; i < 40; i++) begin
      wait_desc(gap, t, ok);
      chk("R7", "descriptor seen", int'(ok), 1);
      chk(i == 0 ? "R2" : "R4", "ticks", t, (i == 0) ? exp_init(op) : exp_poll(op));
      total += t;
      accept_desc(0);
      b = 8'h31 | 8'(op << 6);
      respond(b);
      if (total >= TMO) begin
        check_result(b, 1'b1);
        for (int k = 0; k < 12; k++) begin
          us_tick = 1'b1;
          step();
          chk("R7", "no descriptor after timeout", desc_valid, 0);
        end
        us_tick = 1'b0;
        break;
      end else begin
        chk("R7", "no early timeout", done, 0);
      end
    end
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    chk("R1", "desc_valid after reset", desc_valid, 0);
    chk("R1", "done after reset", done, 0);
    for (int k = 0; k < 6; k++) begin
      us_tick = 1'b1;
      step();
      chk("R1", "idle ticks start nothing", desc_valid | done, 0);
    end
    us_tick = 1'b0;

    for (int op = 0; op < 4; op++)
      for (int ecc = 0; ecc < 4; ecc++)
        for (int nb = 0; nb < 3; nb++)
          run_txn(op, nb, {2'(op), 2'(ecc), 1'(nb), 1'(ecc ^ op), 1'b1, 1'b0},
                  1 + (op + nb) % 3, (ecc + nb) % 3);

    for (int op = 0; op < 4; op++) run_timeout(op, 1 + op % 2);

    begin
      int t;
      bit ok;
      do_start(0);
      us_tick = 1'b1;
      step();
      us_tick = 1'b0;
      start = 1'b1;
      start_op = 2'd2;
      step();
      start = 1'b0;
      wait_desc(1, t, ok);
      chk("R8", "initial ticks kept after second start", t + 1, IR);
      accept_desc(0);
      respond(8'h01);
      wait_desc(2, t, ok);
      chk("R8", "poll of original op kept", t, PR);
      accept_desc(1);
      respond(8'h2C);
      check_result(8'h2C, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule